// File: doc/BRIEF.md
# Q31 Pair Round-Saturate Packer

This block narrows two signed 32-bit Q31 fractional operands to 16-bit Q15 values and packs both into one 32-bit result word. Each operand is rounded to nearest by adding half of the dropped LSB weight (0x00008000) before the low 16 bits are discarded. An operand large enough to carry out of the positive range saturates to the largest Q15 value. Negative operands can never saturate this way.

A saturation on an issue sets a sticky overflow flag, which sits at bit 22 of a small control register. Software writes that register to clear or set the flag and reads it back through a combinational read port. A caller normally writes zero to clear the flag, issues one or more operations, and then reads the register to learn whether any lane saturated.

Top module: `q31_pair_packer`

## Requirements
- R1: After a synchronous active-low reset, `result` is 0x00000000 and `ctl_rdata` is 0x00000000.
- R2: A lane whose signed operand is at most 0x7FFF7FFF produces bits [31:16] of (operand + 0x00008000), taking the operand as signed. For example, 0x865432A0 gives 0x8654 and 0xBEEFFEED gives 0xBEF0.
- R3: A lane whose signed operand is greater than 0x7FFF7FFF produces 0x7FFF and reports overflow, so 0x7FFF8000 and 0x7FFFC678 both saturate. The value 0x7FFF7FFF itself rounds to 0x7FFF without overflow.
- R4: Negative operands never overflow. The operand 0x80000000 gives 0x8000, and 0xFFFFFFFF rounds to 0x0000.
- R5: The lane for `opnd_a` occupies `result[31:16]` and the lane for `opnd_b` occupies `result[15:0]`. Operands 0x7FFFC678 and 0x865432A0 give 0x7FFF8654; operands 0xBEEFFEED and 0x7FFF8000 give 0xBEF07FFF.
- R6: `result` and the flag change only on a rising clock edge where `issue` is 1. While `issue` is 0, operand changes alter neither `result` nor `ctl_rdata`.
- R7: The flag is `ctl_rdata[22]`. It is set on an issue edge if either lane overflows. An issue without overflow never clears it.
- R8: A write (`ctl_we`=1) loads the flag from `ctl_wdata[22]` on that clock edge. Every other bit of `ctl_rdata` always reads 0.
- R9: When a write and an issue fall on the same edge, the flag becomes `ctl_wdata[22]` OR the issue's overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Start a reduce-and-pack operation on this edge |
| opnd_a | input | 32 | Q31 operand for the upper result half |
| opnd_b | input | 32 | Q31 operand for the lower result half |
| result | output | 32 | Registered packed Q15 pair |
| ctl_we | input | 1 | Control-register write enable |
| ctl_wdata | input | 32 | Control-register write data (bit 22 is the flag) |
| ctl_rdata | output | 32 | Current control-register contents |

## Verification
The hardest situation to reach is the exact saturation boundary: a carry out of the signed range happens only for operands from 0x7FFF8000 to 0x7FFFFFFF, and one LSB below that band must round without overflow. The stimulus sweeps the low halves under the upper halves 0x7FFF, 0x8000, 0xFFFF and 0x0000, and it also applies both edges of the band directly. During the sweep every issue comes with a write of zero. That clears any earlier flag, so each vector's own overflow shows in the flag, and the same stimulus also exercises the same-edge write-and-issue rule.

// File: rtl/q31pk_pkg.sv
// Package: shared widths for the Q31 pair packer.
// Assumes a 32-bit Q31 input, a 16-bit Q15 output and two lanes.
package q31pk_pkg;
    localparam int IN_W     = 32;
    localparam int OUT_W    = 16;
    localparam int NLANE    = 2;
    localparam int CTRL_W   = 32;
    localparam int FLAG_POS = 22;
endpackage

// File: rtl/q31pk_lane.sv
// Module: one lane. Rounds a signed IN_W value to OUT_W bits by adding half
// of the dropped LSB weight and then truncating. A carry out of the positive
// range saturates to the largest positive value and raises ovf.
// Assumes IN_W > OUT_W >= 2. Purely combinational.
module q31pk_lane #(
    parameter int IN_W  = q31pk_pkg::IN_W,
    parameter int OUT_W = q31pk_pkg::OUT_W
) (
    input  logic [IN_W-1:0]  x,
    output logic [OUT_W-1:0] q,
    output logic             ovf
);
    localparam int SHIFT = IN_W - OUT_W;
    localparam logic [IN_W:0] HALF_V =
        {{(IN_W-SHIFT+1){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};
    localparam logic [OUT_W-1:0] MAXQ = {1'b0, {(OUT_W-1){1'b1}}};

    logic [IN_W:0] ext;
    logic [IN_W:0] rounded;

    // Widen by one sign bit and add the rounding constant.
    always_comb begin
        ext     = {x[IN_W-1], x};
        rounded = ext + HALF_V;
    end

    // A sign mismatch in the widened sum means the result left the positive range.
    always_comb begin
        ovf = rounded[IN_W] ^ rounded[IN_W-1];
        q   = ovf ? MAXQ : rounded[IN_W-1:SHIFT];
    end
endmodule

// File: rtl/q31pk_result_reg.sv
// Module: holding register for the packed result word.
// Loads on an edge with load=1 and holds otherwise. Synchronous active-low reset to zero.
module q31pk_result_reg #(
    parameter int W = q31pk_pkg::NLANE * q31pk_pkg::OUT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the packed lanes on issue.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/q31pk_ctrl.sv
// Module: control register that holds only the sticky overflow flag.
// A write loads the flag from wdata[FLAG_POS], and an overflow on an issue
// ORs into it. All other read bits are zero. The read path is combinational.
module q31pk_ctrl #(
    parameter int CTRL_W   = q31pk_pkg::CTRL_W,
    parameter int FLAG_POS = q31pk_pkg::FLAG_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              ovf_set,
    output logic [CTRL_W-1:0] rdata
);
    logic flag;

    // The flag takes the write value, then any overflow from this issue is ORed in.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= (we ? wdata[FLAG_POS] : flag) | ovf_set;
    end

    // Place the flag at its bit and read every other bit as zero.
    always_comb begin
        rdata           = '0;
        rdata[FLAG_POS] = flag;
    end

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[FLAG_POS] && !we) |=> rdata[FLAG_POS]);

    // R9
    ovf_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> rdata[FLAG_POS]);
endmodule

// File: rtl/q31_pair_packer.sv
// Module: top level. Two rounding lanes feed a result register, and their
// overflow outputs feed the sticky flag in the control register.
// Assumes a single clock and a synchronous active-low reset. opnd_a lands in the upper half.
module q31_pair_packer #(
    parameter int IN_W     = q31pk_pkg::IN_W,
    parameter int OUT_W    = q31pk_pkg::OUT_W,
    parameter int CTRL_W   = q31pk_pkg::CTRL_W,
    parameter int FLAG_POS = q31pk_pkg::FLAG_POS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue,
    input  logic [IN_W-1:0]     opnd_a,
    input  logic [IN_W-1:0]     opnd_b,
    output logic [2*OUT_W-1:0]  result,
    input  logic                ctl_we,
    input  logic [CTRL_W-1:0]   ctl_wdata,
    output logic [CTRL_W-1:0]   ctl_rdata
);
    localparam int NLANE = 2;
    localparam int SHIFT = IN_W - OUT_W;
    localparam logic [IN_W-1:0] SAT_LIM =
        {1'b0, {(OUT_W-1){1'b1}}, 1'b0, {(SHIFT-1){1'b1}}};
    localparam logic [OUT_W-1:0] MAXQ = {1'b0, {(OUT_W-1){1'b1}}};

    logic [IN_W-1:0]        opnd [NLANE];
    logic [NLANE*OUT_W-1:0] packed_q;
    logic [NLANE-1:0]       lane_ovf;
    logic                   ovf_set;

    // Lane 1 takes opnd_a (upper half) and lane 0 takes opnd_b (lower half).
    always_comb begin
        opnd[1] = opnd_a;
        opnd[0] = opnd_b;
    end

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        q31pk_lane #(.IN_W(IN_W), .OUT_W(OUT_W)) u_lane (
            .x   (opnd[i]),
            .q   (packed_q[i*OUT_W +: OUT_W]),
            .ovf (lane_ovf[i])
        );
    end

    // An overflow counts only on an issue edge.
    always_comb ovf_set = issue & (|lane_ovf);

    q31pk_result_reg #(.W(NLANE*OUT_W)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (issue),
        .d     (packed_q),
        .q     (result)
    );

    q31pk_ctrl #(.CTRL_W(CTRL_W), .FLAG_POS(FLAG_POS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctl_we),
        .wdata   (ctl_wdata),
        .ovf_set (ovf_set),
        .rdata   (ctl_rdata)
    );

    // R3
    sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && ($signed(opnd_a) > $signed(SAT_LIM))) |=>
        (result[2*OUT_W-1:OUT_W] == MAXQ && ctl_rdata[FLAG_POS]));

    // R4
    neg_nosat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && opnd_a[IN_W-1] && opnd_b[IN_W-1] && !ctl_we && !ctl_rdata[FLAG_POS])
        |=> !ctl_rdata[FLAG_POS]);
endmodule

// File: tb/sim_q31_pair_packer.sv
`timescale 1ns/1ps
module sim_q31_pair_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [31:0] result;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] exp_res = '0;
    logic        exp_flag = 1'b0;

    always #4 clk = ~clk;

    q31_pair_packer u0 (
        .clk(clk), .rst_n(rst_n), .issue(issue), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result(result), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
    );

    // Reference model: round by adding 0x8000, shift right by 16 keeping the sign, saturate above 0x7FFF7FFF.
    function automatic logic [15:0] red(input logic [31:0] x, output bit ov);
        longint s;
        longint r;
        s = longint'($signed(x));
        if (s > 64'sh7FFF7FFF) begin
            ov = 1'b1;
            return 16'h7FFF;
        end
        ov = 1'b0;
        r = (s + 32768) >>> 16;
        return r[15:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, update the model, then check both outputs.
    task automatic step(input logic [31:0] a, input logic [31:0] b, input logic iss,
                        input logic we, input logic [31:0] wd, input string tag);
        bit ova, ovb;
        logic [15:0] qa, qb;
        @(negedge clk);
        opnd_a = a; opnd_b = b; issue = iss; ctl_we = we; ctl_wdata = wd;
        qa = red(a, ova);
        qb = red(b, ovb);
        if (iss) exp_res = {qa, qb};
        exp_flag = (we ? wd[22] : exp_flag) | (iss & (ova | ovb));
        @(negedge clk);
        issue = 1'b0; ctl_we = 1'b0;
        chk({tag, " result"}, result, exp_res);
        chk({tag, " ctl_rdata"}, ctl_rdata, {9'b0, exp_flag, 22'b0});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 result", result, 32'h0);
        chk("R1 ctl_rdata", ctl_rdata, 32'h0);

        // R5 R3 first packing vector, flag cleared by the write on the same edge
        step(32'h7FFFC678, 32'h865432A0, 1, 1, 32'h0, "R5 R3 vecA");
        chk("R5 vecA exact", result, 32'h7FFF8654);
        step(32'h0, 32'h0, 0, 1, 32'h0, "R8 clear");
        step(32'hBEEFFEED, 32'h7FFF8000, 1, 0, 32'h0, "R5 R3 vecB");
        chk("R5 vecB exact", result, 32'hBEF07FFF);
        chk("R7 flag set", ctl_rdata, 32'h0040_0000);

        // R7 a non-overflowing issue leaves the flag set
        step(32'h12345678, 32'h00010000, 1, 0, 32'h0, "R7 sticky");
        chk("R7 sticky flag", ctl_rdata, 32'h0040_0000);

        // R8 write clears; other bits read zero
        step(32'h0, 32'h0, 0, 1, 32'h0, "R8 wr0");
        step(32'h0, 32'h0, 0, 1, 32'hFFFFFFFF, "R8 wrall");
        chk("R8 only bit22", ctl_rdata, 32'h0040_0000);
        step(32'h0, 32'h0, 0, 1, 32'hFFBFFFFF, "R8 wr clear bit");
        chk("R8 cleared", ctl_rdata, 32'h0);

        // R3 boundary: 0x7FFF7FFF does not saturate
        step(32'h7FFF7FFF, 32'h7FFF7FFF, 1, 0, 32'h0, "R3 edge");
        chk("R3 edge exact", result, 32'h7FFF7FFF);
        chk("R3 edge noflag", ctl_rdata, 32'h0);
        step(32'h7FFFFFFF, 32'h0, 1, 1, 32'h0, "R3 max");

        // R4 most negative operand and minus one
        step(32'h80000000, 32'hFFFFFFFF, 1, 1, 32'h0, "R4 neg");
        chk("R4 neg exact", result, 32'h80000000);
        chk("R4 noflag", ctl_rdata, 32'h0);

        // R6 operand changes with issue low have no effect
        step(32'h7FFFFFFF, 32'h7FFFFFFF, 0, 0, 32'h0, "R6 hold");
        chk("R6 hold exact", result, 32'h80000000);

        // R9 write of zero together with an overflowing issue leaves the flag set
        step(32'h0, 32'h7FFFFFFF, 1, 1, 32'h0, "R9 ovf wins");
        chk("R9 flag", ctl_rdata, 32'h0040_0000);
        // R9 write of one together with a clean issue
        step(32'h0, 32'h0, 0, 1, 32'h0, "R9 clr");
        step(32'h1, 32'h2, 1, 1, 32'h0040_0000, "R9 write one");

        // R2 R3 sweep of the low halves under the boundary upper halves, with a write of zero on each issue
        for (int u = 0; u < 4; u++) begin
            logic [15:0] up;
            up = (u == 0) ? 16'h7FFF : (u == 1) ? 16'h8000 : (u == 2) ? 16'hFFFF : 16'h0000;
            for (int lo = 0; lo < 65536; lo += 7) begin
                step({up, lo[15:0]}, {lo[15:0] ^ 16'h5A5A, up}, 1, 1, 32'h0, "R2 sweep");
            end
        end
        // R2 sweep across the upper halves at the rounding edges
        for (int hi = 0; hi < 65536; hi += 257) begin
            step({hi[15:0], 16'h7FFF}, {hi[15:0], 16'h8000}, 1, 1, 32'h0, "R2 upper sweep");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule